// File: doc/BRIEF.md
# Programmable Mealy Sequencer Array

This block is the combinational core of a field-configurable Mealy state machine. A programmable AND plane builds 64 product terms. Each term may look at 16 external inputs, 8 state feedback bits and two complement signals. A programmable OR plane then routes any set of those terms onto the J and K inputs of 8 state flip-flops and 8 output flip-flops. The block drives those J/K vectors. The flip-flops that use them sit outside the block and return their state bits on `state_fb`.

Each of the two complement arrays is a NOR over the terms chosen to feed it. Its output goes back into the AND plane as a further literal, so a single term can express an "otherwise" branch. The configuration sits in internal registers and is loaded one term per write through an address/data port that is gated by an enable input. A rule checker watches the stored configuration and drops `cfg_ok` when an entry could form a combinational loop through a complement array, or when one term toggles too many registers.

Top module: `seq_plane`

## Requirements
- R1: After synchronous active-low reset every stored term is dead, all J/K outputs are 0 for any input, and `cfg_ok` is 1.
- R2: A write stores entry `cfg_addr` at a rising edge only when `cfg_we` and `cfg_en` are both 1, and it takes effect from the next cycle. A write made with `cfg_en` at 0 changes nothing.
- R3: The AND mask holds 2 bits per literal, with literal l at bits [2l+1:2l]. Literals 0..15 are `in_vec`, 16..23 are `state_fb` and 24..25 are complement signals 0 and 1. Code 01 needs the literal at 1, code 10 needs it at 0, and code 11 ignores it.
- R4: AND code 00 on any input or state literal forces the term to 0 whatever the inputs are.
- R5: The OR mask holds 2 bits per register, with register g at bits [2g+1:2g]. g 0..7 are the state registers and g 8..15 are output registers 0..7. Code 01 drives J, 10 drives K, 11 drives both (toggle) and 00 drives nothing. Each J or K is the OR of all live terms routed to it.
- R6: When no live term is routed to a register, its J and K are both 0, which is a hold.
- R7: Complement signal a is 1 exactly when no live term that generates into array a is at 1. A term in propagate mode for array a reads that signal through its AND code at literal 24+a.
- R8: The complement code holds 2 bits per array, with array a at bits [2a+1:2a]. 00 kills the term, 01 generates into the array, 10 propagates from it and 11 is transparent (no link, and the literal is ignored).
- R9: `cfg_ok` is 0 while any stored term generates into an array and either has a code other than 11 on that array's literal or is in propagate mode for the other array.
- R10: `cfg_ok` is 0 while any stored term toggles more than 8 registers. Exactly 8 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en | input | 1 | Allows configuration writes |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 6 | Term index to write |
| cfg_and | input | 52 | AND mask for the term |
| cfg_or | input | 32 | OR mask for the term |
| cfg_cmp | input | 4 | Complement codes for the term |
| in_vec | input | 16 | External inputs |
| state_fb | input | 8 | State register feedback |
| st_j | output | 8 | J inputs of the state registers |
| st_k | output | 8 | K inputs of the state registers |
| out_j | output | 8 | J inputs of the output registers |
| out_k | output | 8 | K inputs of the output registers |
| cfg_ok | output | 1 | Stored configuration obeys the loop and toggle rules |

## Verification
Complement generation and complement propagation resolve in the same combinational evaluation. A generating term going live has to flip, within one cycle, the terms that read the complement literal in either polarity. The bench provokes this by stepping the generating input while other terms read the complement in true and in complement form, and it compares the resulting J/K against a model evaluated from the stored entries. A configuration write that lands while inputs are steady is the second overlap: the bench checks that the outputs move only one cycle after an enabled write and never after a disabled one.

// File: rtl/seq_pkg.sv
// Shared codes and helpers for the programmable sequencer array.
// Assumes 2-bit codes for literal, OR and complement fields.
package seq_pkg;

    localparam int DEF_N_IN   = 16;
    localparam int DEF_N_ST   = 8;
    localparam int DEF_N_OUT  = 8;
    localparam int DEF_N_TERM = 64;
    localparam int DEF_N_CMP  = 2;
    localparam int DEF_TOGMAX = 8;

    typedef enum logic [1:0] {
        LIT_KILL = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_ANY  = 2'b11
    } lit_code_e;

    typedef enum logic [1:0] {
        CMP_OFF  = 2'b00,
        CMP_GEN  = 2'b01,
        CMP_PROP = 2'b10,
        CMP_PASS = 2'b11
    } cmp_code_e;

    // Literal match: bit0 of the code admits value 1, bit1 admits value 0.
    function automatic logic lit_pass(input logic [1:0] code, input logic val);
        return val ? code[0] : code[1];
    endfunction

endpackage

// File: rtl/seq_cfg_store.sv
// Configuration store: one entry per product term (AND mask, OR mask,
// complement codes), written through a gated port, plus the rule checker
// that flags loop-prone or over-driving entries.
// Assumes N_TERM entries fit in the address width.
module seq_cfg_store
    import seq_pkg::*;
#(
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_BASE = DEF_N_IN + DEF_N_ST,
    parameter int N_CMP  = DEF_N_CMP,
    parameter int N_REG  = DEF_N_ST + DEF_N_OUT,
    parameter int TOGMAX = DEF_TOGMAX,
    localparam int AW    = $clog2(N_TERM),
    localparam int AND_W = 2 * (N_BASE + N_CMP),
    localparam int OR_W  = 2 * N_REG,
    localparam int CMP_W = 2 * N_CMP
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_en,
    input  logic                              cfg_we,
    input  logic [AW-1:0]                     cfg_addr,
    input  logic [AND_W-1:0]                  cfg_and,
    input  logic [OR_W-1:0]                   cfg_or,
    input  logic [CMP_W-1:0]                  cfg_cmp,
    output logic [N_TERM-1:0][AND_W-1:0]      and_tab,
    output logic [N_TERM-1:0][OR_W-1:0]       or_tab,
    output logic [N_TERM-1:0][CMP_W-1:0]      cmp_tab,
    output logic                              cfg_ok
);

    logic [N_TERM-1:0] viol;

    // Store one term entry per enabled write; reset clears all entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            and_tab <= '0;
            or_tab  <= '0;
            cmp_tab <= '0;
        end else if (cfg_en && cfg_we && (int'(cfg_addr) < N_TERM)) begin
            and_tab[cfg_addr] <= cfg_and;
            or_tab[cfg_addr]  <= cfg_or;
            cmp_tab[cfg_addr] <= cfg_cmp;
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_rule
        logic bad;
        // Flag a term that could loop through a complement array or toggles too many registers.
        always_comb begin : p_rule
            int tog_n;
            bad   = 1'b0;
            tog_n = 0;
            for (int a = 0; a < N_CMP; a++) begin
                if (cmp_tab[t][2*a +: 2] == CMP_GEN) begin
                    if (and_tab[t][2*(N_BASE+a) +: 2] != LIT_ANY) bad = 1'b1;
                    for (int b = 0; b < N_CMP; b++) begin
                        if (b != a && cmp_tab[t][2*b +: 2] == CMP_PROP) bad = 1'b1;
                    end
                end
            end
            for (int g = 0; g < N_REG; g++) begin
                if (&or_tab[t][2*g +: 2]) tog_n = tog_n + 1;
            end
            if (tog_n > TOGMAX) bad = 1'b1;
        end
        assign viol[t] = bad;
    end

    assign cfg_ok = ~|viol;

endmodule

// File: rtl/seq_and_plane.sv
// AND plane: evaluates every term over the input and state literals.
// Complement literals are handled later, in seq_cmp_array.
module seq_and_plane
    import seq_pkg::*;
#(
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_BASE = DEF_N_IN + DEF_N_ST,
    parameter int N_CMP  = DEF_N_CMP,
    localparam int AND_W = 2 * (N_BASE + N_CMP)
) (
    input  logic [N_TERM-1:0][AND_W-1:0] and_tab,
    input  logic [N_BASE-1:0]            lit_vec,
    output logic [N_TERM-1:0]            base_t
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic hit;
        // A term is high only when every input/state literal admits its value.
        always_comb begin : p_match
            hit = 1'b1;
            for (int l = 0; l < N_BASE; l++) begin
                if (!lit_pass(and_tab[t][2*l +: 2], lit_vec[l])) hit = 1'b0;
            end
        end
        assign base_t[t] = hit;
    end

endmodule

// File: rtl/seq_cmp_array.sv
// Complement arrays: NOR of generating terms, fed back to propagating
// terms. Generating terms are evaluated without complement literals so
// the structure has no combinational loop.
module seq_cmp_array
    import seq_pkg::*;
#(
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_BASE = DEF_N_IN + DEF_N_ST,
    parameter int N_CMP  = DEF_N_CMP,
    localparam int AND_W = 2 * (N_BASE + N_CMP),
    localparam int CMP_W = 2 * N_CMP
) (
    input  logic [N_TERM-1:0][AND_W-1:0] and_tab,
    input  logic [N_TERM-1:0][CMP_W-1:0] cmp_tab,
    input  logic [N_TERM-1:0]            base_t,
    output logic [N_CMP-1:0]             c_lvl,
    output logic [N_TERM-1:0]            term_v
);

    logic [N_TERM-1:0]             armed;
    logic [N_CMP-1:0][N_TERM-1:0]  feed;

    for (genvar t = 0; t < N_TERM; t++) begin : g_arm
        logic ok;
        // A term is armed when its base matches and no complement code kills it.
        always_comb begin : p_arm
            ok = base_t[t];
            for (int a = 0; a < N_CMP; a++) begin
                if (cmp_tab[t][2*a +: 2] == CMP_OFF) ok = 1'b0;
            end
        end
        assign armed[t] = ok;
    end

    for (genvar a = 0; a < N_CMP; a++) begin : g_arr
        for (genvar t = 0; t < N_TERM; t++) begin : g_src
            assign feed[a][t] = armed[t] && (cmp_tab[t][2*a +: 2] == CMP_GEN);
        end
        // Complement output is high only while no generating term is live.
        assign c_lvl[a] = ~|feed[a];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_fin
        logic live;
        // Apply complement literals to terms in propagate mode.
        always_comb begin : p_prop
            live = armed[t];
            for (int a = 0; a < N_CMP; a++) begin
                if (cmp_tab[t][2*a +: 2] == CMP_PROP &&
                    !lit_pass(and_tab[t][2*(N_BASE+a) +: 2], c_lvl[a])) live = 1'b0;
            end
        end
        assign term_v[t] = live;
    end

endmodule

// File: rtl/seq_or_plane.sv
// OR plane: routes live terms onto the J and K inputs of every register.
// Register g uses OR-mask bits [2g+1:2g]: bit0 drives J, bit1 drives K.
module seq_or_plane #(
    parameter int N_TERM = 64,
    parameter int N_REG  = 16,
    localparam int OR_W  = 2 * N_REG
) (
    input  logic [N_TERM-1:0][OR_W-1:0] or_tab,
    input  logic [N_TERM-1:0]           term_v,
    output logic [N_REG-1:0]            j_vec,
    output logic [N_REG-1:0]            k_vec
);

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        logic [N_TERM-1:0] j_col;
        logic [N_TERM-1:0] k_col;
        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            assign j_col[t] = or_tab[t][2*g];
            assign k_col[t] = or_tab[t][2*g+1];
        end
        // J and K are the OR of live terms connected to them.
        assign j_vec[g] = |(term_v & j_col);
        assign k_vec[g] = |(term_v & k_col);
    end

endmodule

// File: rtl/seq_plane.sv
// Top of the programmable Mealy sequencer array. Combines the config
// store, AND plane, complement arrays and OR plane. The J/K outputs are
// combinational in the inputs and the stored configuration.
module seq_plane
    import seq_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_ST   = DEF_N_ST,
    parameter int N_OUT  = DEF_N_OUT,
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_CMP  = DEF_N_CMP,
    parameter int TOGMAX = DEF_TOGMAX,
    localparam int N_BASE = N_IN + N_ST,
    localparam int N_REG  = N_ST + N_OUT,
    localparam int AW     = $clog2(N_TERM),
    localparam int AND_W  = 2 * (N_BASE + N_CMP),
    localparam int OR_W   = 2 * N_REG,
    localparam int CMP_W  = 2 * N_CMP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [AND_W-1:0] cfg_and,
    input  logic [OR_W-1:0]  cfg_or,
    input  logic [CMP_W-1:0] cfg_cmp,
    input  logic [N_IN-1:0]  in_vec,
    input  logic [N_ST-1:0]  state_fb,
    output logic [N_ST-1:0]  st_j,
    output logic [N_ST-1:0]  st_k,
    output logic [N_OUT-1:0] out_j,
    output logic [N_OUT-1:0] out_k,
    output logic             cfg_ok
);

    logic [N_TERM-1:0][AND_W-1:0] and_tab;
    logic [N_TERM-1:0][OR_W-1:0]  or_tab;
    logic [N_TERM-1:0][CMP_W-1:0] cmp_tab;
    logic [N_TERM-1:0]            base_t;
    logic [N_TERM-1:0]            term_v;
    logic [N_CMP-1:0]             c_lvl;
    logic [N_REG-1:0]             j_vec;
    logic [N_REG-1:0]             k_vec;

    seq_cfg_store #(
        .N_TERM(N_TERM), .N_BASE(N_BASE), .N_CMP(N_CMP),
        .N_REG(N_REG), .TOGMAX(TOGMAX)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .cfg_cmp(cfg_cmp), .and_tab(and_tab), .or_tab(or_tab),
        .cmp_tab(cmp_tab), .cfg_ok(cfg_ok)
    );

    seq_and_plane #(
        .N_TERM(N_TERM), .N_BASE(N_BASE), .N_CMP(N_CMP)
    ) u_and (
        .and_tab(and_tab), .lit_vec({state_fb, in_vec}), .base_t(base_t)
    );

    seq_cmp_array #(
        .N_TERM(N_TERM), .N_BASE(N_BASE), .N_CMP(N_CMP)
    ) u_cmp (
        .and_tab(and_tab), .cmp_tab(cmp_tab), .base_t(base_t),
        .c_lvl(c_lvl), .term_v(term_v)
    );

    seq_or_plane #(
        .N_TERM(N_TERM), .N_REG(N_REG)
    ) u_or (
        .or_tab(or_tab), .term_v(term_v), .j_vec(j_vec), .k_vec(k_vec)
    );

    assign st_j  = j_vec[N_ST-1:0];
    assign st_k  = k_vec[N_ST-1:0];
    assign out_j = j_vec[N_REG-1:N_ST];
    assign out_k = k_vec[N_REG-1:N_ST];

endmodule

// File: rtl/seq_plane_chk.sv
// Checker for seq_plane, attached by bind. Observes ports and the
// term/complement nets that separate sub-blocks drive.
module seq_plane_chk #(
    parameter int N_IN   = 16,
    parameter int N_ST   = 8,
    parameter int N_OUT  = 8,
    parameter int N_TERM = 64,
    parameter int N_CMP  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              cfg_we,
    input logic [N_IN-1:0]   in_vec,
    input logic [N_ST-1:0]   state_fb,
    input logic [N_ST-1:0]   st_j,
    input logic [N_ST-1:0]   st_k,
    input logic [N_OUT-1:0]  out_j,
    input logic [N_OUT-1:0]  out_k,
    input logic              cfg_ok,
    input logic [N_TERM-1:0] term_v,
    input logic [N_CMP-1:0]  c_lvl
);

    // Leaving reset: all J/K quiet and configuration legal.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_j == '0 && st_k == '0 && out_j == '0 && out_k == '0 && cfg_ok));

    // Without an enabled write and with steady inputs, nothing moves.
    assert_no_write_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_en) |=> (!$stable(in_vec) || !$stable(state_fb) ||
            ($stable(st_j) && $stable(st_k) && $stable(out_j) && $stable(out_k) && $stable(cfg_ok))));

    // No live term means every register holds.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (term_v == '0) |-> (st_j == '0 && st_k == '0 && out_j == '0 && out_k == '0));

    // A low complement signal requires some live term in a legal configuration.
    assert_cmp_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok && c_lvl != '1) |-> (term_v != '0));

endmodule

bind seq_plane seq_plane_chk #(
    .N_IN(N_IN), .N_ST(N_ST), .N_OUT(N_OUT), .N_TERM(N_TERM), .N_CMP(N_CMP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .in_vec(in_vec), .state_fb(state_fb), .st_j(st_j), .st_k(st_k),
    .out_j(out_j), .out_k(out_k), .cfg_ok(cfg_ok), .term_v(term_v),
    .c_lvl(c_lvl)
);

// File: tb/sim_seq_plane.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected J/K from a requirement
// model of the stored entries; the monitor pops and compares after settle.
module sim_seq_plane;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [51:0] cfg_and = '0;
    logic [31:0] cfg_or = '0;
    logic [3:0]  cfg_cmp = '0;
    logic [15:0] in_vec = '0;
    logic [7:0]  state_fb = '0;
    logic [7:0]  st_j, st_k, out_j, out_k;
    logic        cfg_ok;

    logic [51:0] sh_and [64];
    logic [31:0] sh_or  [64];
    logic [3:0]  sh_cmp [64];

    typedef struct {
        logic [31:0] jk;
        logic        ok;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seq_plane u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .cfg_cmp(cfg_cmp), .in_vec(in_vec), .state_fb(state_fb),
        .st_j(st_j), .st_k(st_k), .out_j(out_j), .out_k(out_k),
        .cfg_ok(cfg_ok)
    );

    function automatic logic hit(input logic [1:0] c, input logic v);
        return v ? c[0] : c[1];
    endfunction

    // Expected {out_k, out_j, st_k, st_j} from the shadow entries.
    function automatic logic [31:0] model(input logic [15:0] iv, input logic [7:0] sv);
        logic [23:0] lv;
        logic [63:0] armed, full;
        logic [1:0]  c;
        logic [15:0] j, k;
        lv = {sv, iv};
        for (int t = 0; t < 64; t++) begin
            armed[t] = 1'b1;
            for (int l = 0; l < 24; l++)
                if (!hit(sh_and[t][2*l +: 2], lv[l])) armed[t] = 1'b0;
            for (int a = 0; a < 2; a++)
                if (sh_cmp[t][2*a +: 2] == 2'b00) armed[t] = 1'b0;
        end
        for (int a = 0; a < 2; a++) begin
            c[a] = 1'b1;
            for (int t = 0; t < 64; t++)
                if (armed[t] && sh_cmp[t][2*a +: 2] == 2'b01) c[a] = 1'b0;
        end
        j = '0; k = '0;
        for (int t = 0; t < 64; t++) begin
            full[t] = armed[t];
            for (int a = 0; a < 2; a++)
                if (sh_cmp[t][2*a +: 2] == 2'b10 && !hit(sh_and[t][2*(24+a) +: 2], c[a]))
                    full[t] = 1'b0;
            if (full[t]) begin
                for (int g = 0; g < 16; g++) begin
                    if (sh_or[t][2*g])   j[g] = 1'b1;
                    if (sh_or[t][2*g+1]) k[g] = 1'b1;
                end
            end
        end
        return {k[15:8], j[15:8], k[7:0], j[7:0]};
    endfunction

    function automatic logic model_ok();
        for (int t = 0; t < 64; t++) begin
            int n = 0;
            for (int a = 0; a < 2; a++)
                if (sh_cmp[t][2*a +: 2] == 2'b01 &&
                    (sh_and[t][2*(24+a) +: 2] != 2'b11 || sh_cmp[t][2*(1-a) +: 2] == 2'b10))
                    return 1'b0;
            for (int g = 0; g < 16; g++) if (&sh_or[t][2*g +: 2]) n++;
            if (n > 8) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic clear_shadow();
        for (int t = 0; t < 64; t++) begin
            sh_and[t] = '0; sh_or[t] = '0; sh_cmp[t] = '0;
        end
    endtask

    task automatic wr(input int a, input logic [51:0] am, input logic [31:0] om,
                      input logic [3:0] cm, input logic en);
        @(negedge clk);
        cfg_addr = 6'(a); cfg_and = am; cfg_or = om; cfg_cmp = cm;
        cfg_en = en; cfg_we = 1'b1;
        if (en) begin
            sh_and[a] = am; sh_or[a] = om; sh_cmp[a] = cm;
        end
        @(negedge clk);
        cfg_we = 1'b0; cfg_en = 1'b0;
    endtask

    task automatic chk(input logic [15:0] iv, input logic [7:0] sv, input string tag);
        exp_t e;
        @(negedge clk);
        in_vec = iv; state_fb = sv;
        e.jk = model(iv, sv); e.ok = model_ok(); e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Monitor: compare after the inputs of the current cycle settle.
    initial begin : p_mon
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if ({out_k, out_j, st_k, st_j} !== e.jk) begin
                    n_fail++;
                    $display("FAIL %s: jk got %h exp %h", e.tag, {out_k, out_j, st_k, st_j}, e.jk);
                end
                n_run++;
                if (cfg_ok !== e.ok) begin
                    n_fail++;
                    $display("FAIL %s: cfg_ok got %b exp %b", e.tag, cfg_ok, e.ok);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin : p_wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
            $finish;
        end
    end

    initial begin : p_main
        logic [51:0] m;
        clear_shadow();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(16'hFFFF, 8'hFF, "R1 reset all quiet");
        chk(16'h0000, 8'h00, "R1 reset all quiet zero inputs");

        // Term 0: in0 true, in3 complement, state bit2 true; set st0, reset out5, toggle st7.
        m = '1; m[1:0] = 2'b01; m[7:6] = 2'b10; m[2*18 +: 2] = 2'b01;
        wr(0, m, 32'h0800_C001, 4'b1111, 1'b1);
        chk(16'h0001, 8'h04, "R3 R5 term0 match");
        chk(16'h0009, 8'h04, "R3 complement literal blocks");
        chk(16'h0001, 8'h00, "R3 state literal blocks");
        chk(16'hFFF1, 8'hFB, "R3 dont-care literals");
        chk(16'h0000, 8'h00, "R6 no live term holds");

        // Term 1 written with enable low must not appear.
        wr(1, '1, 32'h0001_0000, 4'b1111, 1'b0);
        chk(16'h0000, 8'h00, "R2 disabled write ignored");
        wr(1, '1, 32'h0001_0000, 4'b1111, 1'b1);
        chk(16'h0000, 8'h00, "R2 enabled write visible");

        // Term 2 killed by code 00 on in5.
        m = '1; m[11:10] = 2'b00;
        wr(2, m, 32'h0010_0000, 4'b1111, 1'b1);
        chk(16'h0020, 8'h00, "R4 killed term in5 high");
        chk(16'h0000, 8'h00, "R4 killed term in5 low");

        // Term 3 generates C0 from in8; terms 4/5 read C0 in both polarities; term 6 killed by cmp code.
        m = '1; m[17:16] = 2'b01;
        wr(3, m, 32'h0, 4'b1101, 1'b1);
        m = '1; m[2*24 +: 2] = 2'b01;
        wr(4, m, 32'h0000_0040, 4'b1110, 1'b1);
        m = '1; m[2*24 +: 2] = 2'b10;
        wr(5, m, 32'h2000_0000, 4'b1110, 1'b1);
        wr(6, '1, 32'h4000_0000, 4'b1100, 1'b1);
        chk(16'h0000, 8'h00, "R7 complement high with no generator");
        chk(16'h0100, 8'h00, "R7 complement low when generator live");
        chk(16'h0101, 8'h04, "R7 complement with term0 live");
        chk(16'h0000, 8'hFF, "R8 cmp code 00 kills term6");

        // Loop rules.
        m = '1; m[19:18] = 2'b01; m[2*25 +: 2] = 2'b01;
        wr(7, m, 32'h0, 4'b0111, 1'b1);
        chk(16'h0000, 8'h00, "R9 generate reads own literal");
        m = '1; m[19:18] = 2'b01;
        wr(7, m, 32'h0, 4'b1001, 1'b1);
        chk(16'h0000, 8'h00, "R9 generate plus cross propagate");
        chk(16'h0200, 8'h00, "R9 cross generator pulls C0");
        wr(7, '0, 32'h0, 4'b0000, 1'b1);
        chk(16'h0000, 8'h00, "R9 cleared entry legal");

        // Toggle limit.
        wr(8, '0, 32'hFFFF_FFFF, 4'b0000, 1'b1);
        chk(16'h0000, 8'h00, "R10 sixteen toggles rejected");
        wr(8, '0, 32'h0000_FFFF, 4'b0000, 1'b1);
        chk(16'h0000, 8'h00, "R10 eight toggles accepted");
        wr(8, '0, 32'h0003_FFFF, 4'b0000, 1'b1);
        chk(16'h0000, 8'h00, "R10 nine toggles rejected");
        wr(8, '0, 32'h0, 4'b0000, 1'b1);

        // Reset again clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        clear_shadow();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(16'h0101, 8'h04, "R1 second reset clears table");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule